// File: doc/BRIEF.md
# Frame timing and delayed status generator

This block divides a free-running core clock into video frames of fixed length. The frame length is the core clock frequency divided by the frame rate. Each frame opens with a short vertical-blank interval, and a vertical-blank interrupt is raised at that point. The rest of the frame is display time.

At the same frame boundary a status flag is armed. It stays set for a number of cycles that depends on a 2-bit timing mode, counted from the start of vertical blank, and is then cleared. The delay is independent of the vertical-blank interval. The flag is presented on two read words with different encodings. Software polls one of them to pace its frame loop.

All outputs are plain control and status levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure. The interrupt output is a level that holds until it is acknowledged.

Top module: `ftg_frame_timer`

## Requirements
- R1: The frame period is FRAME_CYC = CLK_HZ / FRAME_HZ cycles, with the fraction truncated. A new frame starts every FRAME_CYC cycles.
- R2: `vblank_o` is high for the first VBL_CYC = floor(FRAME_CYC * 25 / 1000) cycles of each frame and low for the remaining cycles.
- R3: `irq_o` goes high in the first cycle of each frame and stays high until `irq_ack_i` is sampled high on a clock edge. It is then low from the next cycle. An acknowledge sampled on the edge that starts a frame loses to the new request.
- R4: The status flag is high for the first DLY cycles of each frame and low for the rest. DLY is the frame length times a percentage, truncated. The percentage is selected by `mode_i`: 0 gives 48%, 1 gives 4.8%, 2 gives 9.12% and 3 gives 24%.
- R5: `mode_i` is sampled only on the edge that starts a frame, which is the edge that ends the frame's last cycle. A change to `mode_i` at any other time has no effect on the current frame's flag length.
- R6: `status_word_o` is 32'hFFFFFFFF while the flag is high and 32'hFFFFFFFD while it is low. Only bit 1 varies.
- R7: `status_mask_o` is all ones while the flag is high and all zeros while it is low.
- R8: While `rst_n` is low, `vblank_o` and `irq_o` are 0, `status_word_o` is 32'hFFFFFFFD and `status_mask_o` is 0. The first frame starts on the first clock edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Status delay mode, sampled at the frame boundary |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| vblank_o | output | 1 | Vertical-blank interval |
| irq_o | output | 1 | Vertical-blank interrupt level |
| status_word_o | output | 32 | Status read word, bit 1 is the flag |
| status_mask_o | output | 32 | Status read word, flag replicated over all bits |

## Verification
Every output is decoded from registers alone. So `vblank_o`, `irq_o` and both status words change on the edge that ends a frame's last cycle, and the new values are visible in the first cycle of the next frame. The mode used for a frame is the one present during the last cycle of the previous frame. An acknowledge takes effect one cycle after the edge that samples it.

The bench updates a behavioural model on the same rising edge as the design, with inputs driven on falling edges. It compares all outputs on the following falling edge, so each result is checked in the cycle where it is due. Frame-level checks count flag cycles and vblank spacing over whole frames.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  typedef enum logic [1:0] {
    MODE_LONG  = 2'd0,
    MODE_SHORT = 2'd1,
    MODE_MID   = 2'd2,
    MODE_HALF  = 2'd3
  } ftg_mode_e;

  localparam int unsigned BP_SCALE = 10000;
  localparam int unsigned VBL_BP   = 250;

  function automatic int unsigned mode_bp(input int unsigned m);
    case (m)
      0:       mode_bp = 4800;
      1:       mode_bp = 480;
      2:       mode_bp = 912;
      default: mode_bp = 2400;
    endcase
  endfunction

  function automatic int unsigned frac_cycles(input int unsigned frame, input int unsigned bp);
    longint unsigned prod;
    prod = longint'(frame) * longint'(bp);
    frac_cycles = int'(prod / BP_SCALE);
  endfunction

endpackage

// File: rtl/ftg_frame_counter.sv
module ftg_frame_counter #(
  parameter int unsigned FRAME_CYC = 10000,
  parameter int unsigned VBL_CYC   = 250,
  parameter int unsigned PW        = $clog2(FRAME_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pos_o,
  output logic          last_o,
  output logic          vblank_o
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_CYC - 1);
  localparam logic [PW-1:0] VBL  = PW'(VBL_CYC);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pos_q <= LAST;
    else if (pos_q == LAST)  pos_q <= '0;
    else                     pos_q <= pos_q + 1'b1;
  end

  assign pos_o    = pos_q;
  assign last_o   = (pos_q == LAST);
  assign vblank_o = (pos_q < VBL);

  a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n) pos_q <= LAST);
  a_r1_wrap:      assert property (@(posedge clk) disable iff (!rst_n) last_o |=> (pos_q == '0));
  a_r2_vbl_start: assert property (@(posedge clk) disable iff (!rst_n) last_o |=> vblank_o);
  a_r2_vbl_hold:  assert property (@(posedge clk) disable iff (!rst_n) (!vblank_o && !last_o) |=> !vblank_o);
endmodule

// File: rtl/ftg_status_timer.sv
module ftg_status_timer
  import ftg_pkg::*;
#(
  parameter int unsigned FRAME_CYC = 10000,
  parameter int unsigned PW        = $clog2(FRAME_CYC),
  parameter int unsigned STATUS_W  = 32,
  parameter int unsigned FLAG_BIT  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                last_i,
  input  logic [PW-1:0]       pos_i,
  input  logic [1:0]          mode_i,
  output logic                flag_o,
  output logic [STATUS_W-1:0] word_o,
  output logic [STATUS_W-1:0] mask_o
);
  localparam int unsigned NMODE = 4;

  logic [PW-1:0] dly_tab [NMODE];
  logic [PW-1:0] dly_q;

  for (genvar g = 0; g < NMODE; g++) begin : g_dly
    localparam int unsigned D = frac_cycles(FRAME_CYC, mode_bp(g));
    assign dly_tab[g] = PW'(D);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (last_i) dly_q <= dly_tab[mode_i];
  end

  assign flag_o = (pos_i < dly_q);

  always_comb begin
    word_o           = '1;
    word_o[FLAG_BIT] = flag_o;
  end

  assign mask_o = {STATUS_W{flag_o}};

  a_r5_no_midframe_arm: assert property (@(posedge clk) disable iff (!rst_n) (!last_i && !flag_o) |=> !flag_o);
  a_r4_clear_by_end:    assert property (@(posedge clk) disable iff (!rst_n) last_i |-> !flag_o);
  a_r4_stable_delay:    assert property (@(posedge clk) disable iff (!rst_n) !last_i |=> $stable(dly_q));
endmodule

// File: rtl/ftg_irq_latch.sv
module ftg_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r3_set:   assert property (@(posedge clk) disable iff (!rst_n) set_i |=> irq_o);
  a_r3_hold:  assert property (@(posedge clk) disable iff (!rst_n) (irq_o && !ack_i) |=> irq_o);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n) (ack_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/ftg_frame_timer.sv
module ftg_frame_timer
  import ftg_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 600000,
  parameter int unsigned FRAME_HZ = 60,
  parameter int unsigned STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                irq_ack_i,
  output logic                vblank_o,
  output logic                irq_o,
  output logic [STATUS_W-1:0] status_word_o,
  output logic [STATUS_W-1:0] status_mask_o
);
  localparam int unsigned FRAME_CYC = CLK_HZ / FRAME_HZ;
  localparam int unsigned VBL_CYC   = frac_cycles(FRAME_CYC, VBL_BP);
  localparam int unsigned PW        = $clog2(FRAME_CYC);

  logic [PW-1:0] pos;
  logic          last;
  logic          flag;

  ftg_frame_counter #(.FRAME_CYC(FRAME_CYC), .VBL_CYC(VBL_CYC), .PW(PW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pos_o(pos), .last_o(last), .vblank_o(vblank_o)
  );

  ftg_status_timer #(.FRAME_CYC(FRAME_CYC), .PW(PW), .STATUS_W(STATUS_W), .FLAG_BIT(1)) u_stat (
    .clk(clk), .rst_n(rst_n), .last_i(last), .pos_i(pos), .mode_i(mode_i),
    .flag_o(flag), .word_o(status_word_o), .mask_o(status_mask_o)
  );

  ftg_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(last), .ack_i(irq_ack_i), .irq_o(irq_o)
  );

  a_r3_irq_with_vblank: assert property (@(posedge clk) disable iff (!rst_n) $rose(vblank_o) |-> irq_o);
  a_r7_mask_onehot:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~status_word_o));
endmodule

// File: tb/tb_ftg_frame_timer.sv
module tb_ftg_frame_timer;
  localparam int unsigned CLK_HZ = 60000;
  localparam int F   = CLK_HZ / 60;
  localparam int VBL = F * 250 / 10000;

  logic clk = 0, rst_n = 0, irq_ack_i = 0;
  logic [1:0] mode_i = 0;
  logic vblank_o, irq_o;
  logic [31:0] status_word_o, status_mask_o;

  ftg_frame_timer #(.CLK_HZ(CLK_HZ)) dut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int m_pos = F - 1, m_dly = 0, m_irq = 0, m_mode = 0;
  int flag_cnt = 0, prev_dly = 0, frames = 0, last_rise = -1, cyc = 0;
  bit r5_frame = 0, r5_prev = 0, done = 0;

  function automatic int dly_of(input int m);
    case (m)
      0: return F * 4800 / 10000;
      1: return F * 480 / 10000;
      2: return F * 912 / 10000;
      default: return F * 2400 / 10000;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pos = F - 1; m_dly = 0; m_irq = 0;
    end else if (m_pos == F - 1) begin
      m_pos = 0; m_dly = dly_of(int'(mode_i)); m_mode = int'(mode_i); m_irq = 1;
    end else begin
      m_pos++;
      if (irq_ack_i) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R8 vblank in reset", vblank_o, 0);
      chk("R8 irq in reset", irq_o, 0);
      chk("R8 word in reset", status_word_o, 32'hFFFFFFFD);
      chk("R8 mask in reset", status_mask_o, 0);
    end else if (!done) begin
      automatic bit fl = (m_pos < m_dly);
      chk("R2 vblank", vblank_o, (m_pos < VBL));
      chk("R3 irq", irq_o, m_irq);
      chk("R6 word", status_word_o, fl ? 32'hFFFFFFFF : 32'hFFFFFFFD);
      chk("R7 mask", status_mask_o, fl ? 32'hFFFFFFFF : 32'h0);
      if (m_pos == 0) begin
        if (last_rise >= 0) chk("R1 frame period", cyc - last_rise, F);
        if (frames > 0) chk(r5_prev ? "R5 mode change mid-frame ignored" : "R4 flag length",
                            flag_cnt, prev_dly);
        last_rise = cyc; flag_cnt = 0; prev_dly = m_dly; frames++;
        r5_prev = r5_frame; r5_frame = 0;
      end
      if (status_mask_o[0]) flag_cnt++;
    end
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (m_pos != p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    mode_i = 0;
    wait_pos(100);
    irq_ack_i = 1; @(negedge clk); irq_ack_i = 0;
    wait_pos(F - 2); mode_i = 1;
    wait_pos(10);
    r5_frame = 1; mode_i = 3;
    wait_pos(F - 2); mode_i = 2;
    wait_pos(F - 1); irq_ack_i = 1;
    @(negedge clk); irq_ack_i = 0;
    wait_pos(F - 2); mode_i = 3;
    wait_pos(300); irq_ack_i = 1; @(negedge clk); irq_ack_i = 0;
    wait_pos(F - 2); mode_i = 0;
    wait_pos(F - 2); mode_i = 1;
    wait_pos(5); irq_ack_i = 1; @(negedge clk); irq_ack_i = 0;
    wait_pos(1);
    chk("R4 mode 1 flag length", prev_dly, 48);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule